// File: doc/BRIEF.md
# Timing-Track Sequential Answer Grader

This block grades a multiple-choice answer sheet one question at a time as the sheet moves past a scanner. Every question has four options, and the answer key holds one one-hot nibble per question, written before the scan through an index and a write strobe. The scanner delivers four option-sense bits and one timing-track bit. The timing-track bit comes from a column that is shaded on every row, so the unshaded strip between two rows marks the move to the next question.

The timing track is synchronised and filtered. Each accepted shaded-to-gap transition grades the question just scanned and then advances the question index. Grading compares the option bits with the key entry for that question. The block keeps a tally of correct answers and a tally of wrong answers, and forms a net score from them that never drops below zero. Both the correct tally and the net score are also given as two-digit BCD for display. A programmable question limit ends the scan early. After the last question, a done flag freezes the block until reset.

Top module: `sheet_grader`

## Requirements
- R1: While rst_ni is low and right after it rises, the question index, both tallies, the score, all BCD digits and done_o are zero, and every key entry is cleared to 4'b0000. A blank answer (4'b0000) to a question whose key was never written after reset therefore grades as correct.
- R2: When key_we_i is high at a clock edge, key_data_i is stored as the key for question key_idx_i. Bit 0 is option A, bit 1 is B, bit 2 is C and bit 3 is D.
- R3: track_i passes through a two-flop synchroniser and a debounce filter. The filter changes state only after the synchronised level has differed from it for FILT_N consecutive cycles (default 4). A gap shorter than FILT_N cycles grades nothing.
- R4: Each accepted shaded-to-gap transition grades exactly one question and raises q_idx_o by one. The opt_i bits are sampled in the cycle of the one-cycle advance pulse, which falls FILT_N+2 cycles after the gap reaches track_i. The tallies and index update on the next edge.
- R5: A question grades as correct only when all four opt_i bits equal the stored key entry. Any other pattern, including a blank or more than one mark, grades as wrong.
- R6: score_o equals correct_o minus wrong_o when correct_o is not less than wrong_o, and zero otherwise.
- R7: corr_tens_o/corr_units_o and score_tens_o/score_units_o give the decimal tens and units digits of correct_o and score_o.
- R8: The effective limit is q_limit_i when it lies in 1..NUM_Q, and NUM_Q otherwise. Once that many questions are graded, done_o goes high and stays high. Later gaps then change neither the index nor the tallies until reset.
- R9: If a key write hits the current question in the same cycle as its advance pulse, the question is graded against the entry stored before that write.
- R10: correct_o plus wrong_o always equals q_idx_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_we_i | input | 1 | Key write strobe |
| key_idx_i | input | IDX_W | Question index of the key write |
| key_data_i | input | 4 | One-hot key entry (bit 0 = A) |
| q_limit_i | input | CNT_W | Number of questions to grade (0 or >NUM_Q means NUM_Q) |
| opt_i | input | 4 | Scanned option marks (bit 0 = A) |
| track_i | input | 1 | Timing-track sense, 1 = shaded |
| q_idx_o | output | CNT_W | Questions graded so far |
| correct_o | output | CNT_W | Correct tally |
| wrong_o | output | CNT_W | Wrong tally |
| score_o | output | CNT_W | Net score clamped at zero |
| corr_tens_o | output | 4 | Tens digit of the correct tally |
| corr_units_o | output | 4 | Units digit of the correct tally |
| score_tens_o | output | 4 | Tens digit of the score |
| score_units_o | output | 4 | Units digit of the score |
| done_o | output | 1 | Limit reached, held until reset |

## Verification
A key write and the grading of a question can land in the same clock. The bench counts the synchroniser and filter stages from the moment it drops the timing track. It then drives a key write to the current question exactly in the advance-pulse cycle, with options that match the old entry and not the new one. The result is judged at the tally ports: a correct increment shows that the read happened before the write, and a wrong increment exposes a write-first path.

// File: rtl/grader_pkg.sv
`timescale 1ns/1ps
package grader_pkg;
  localparam int unsigned OPT_N = 4;
  typedef logic [OPT_N-1:0] opt_t;
endpackage

// File: rtl/track_filter.sv
`timescale 1ns/1ps
module track_filter #(
  parameter int unsigned FILT_N = 4,
  localparam int unsigned FC_W = (FILT_N > 1) ? $clog2(FILT_N) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic track_i,
  output logic adv_o
);
  logic s1_q, s2_q, filt_q, adv_q;
  logic [FC_W-1:0] cnt_q;
  logic flip;

  assign flip = (s2_q != filt_q) && (cnt_q == FC_W'(FILT_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
      adv_q  <= 1'b0;
    end else begin
      s1_q  <= track_i;
      s2_q  <= s1_q;
      adv_q <= flip && filt_q;  // shaded -> gap
      if (s2_q == filt_q) begin
        cnt_q <= '0;
      end else if (flip) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign adv_o = adv_q;
endmodule

// File: rtl/key_store.sv
`timescale 1ns/1ps
module key_store import grader_pkg::*; #(
  parameter int unsigned NUM_Q = 10,
  parameter int unsigned IDX_W = $clog2(NUM_Q),
  parameter int unsigned CNT_W = $clog2(NUM_Q + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  opt_t             wdata_i,
  input  logic [CNT_W-1:0] ridx_i,
  output opt_t             rdata_o
);
  opt_t key_q [NUM_Q];

  for (genvar i = 0; i < NUM_Q; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           key_q[i] <= '0;
      else if (we_i && widx_i == IDX_W'(i))  key_q[i] <= wdata_i;
    end
  end

  // one selector per option bit
  for (genvar j = 0; j < OPT_N; j++) begin : g_sel
    always_comb begin
      rdata_o[j] = 1'b0;
      for (int i = 0; i < NUM_Q; i++) begin
        rdata_o[j] = rdata_o[j] | ((ridx_i == CNT_W'(i)) & key_q[i][j]);
      end
    end
  end
endmodule

// File: rtl/grade_tally.sv
`timescale 1ns/1ps
module grade_tally import grader_pkg::*; #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  opt_t             opt_i,
  input  opt_t             key_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] idx_o,
  output logic [CNT_W-1:0] correct_o,
  output logic [CNT_W-1:0] wrong_o,
  output logic [CNT_W-1:0] score_o,
  output logic             done_o
);
  logic [CNT_W-1:0] idx_q, cor_q, wrg_q, idx_nx;
  logic done_q, hit;

  assign hit    = (opt_i == key_i);
  assign idx_nx = idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      cor_q  <= '0;
      wrg_q  <= '0;
      done_q <= 1'b0;
    end else if (adv_i && !done_q) begin
      idx_q <= idx_nx;
      if (hit) cor_q <= cor_q + 1'b1;
      else     wrg_q <= wrg_q + 1'b1;
      if (idx_nx >= limit_i) done_q <= 1'b1;
    end
  end

  assign idx_o     = idx_q;
  assign correct_o = cor_q;
  assign wrong_o   = wrg_q;
  assign done_o    = done_q;
  assign score_o   = (cor_q >= wrg_q) ? (cor_q - wrg_q) : '0;
endmodule

// File: rtl/bcd_split.sv
`timescale 1ns/1ps
module bcd_split #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] bin_i,
  output logic [3:0]   tens_o,
  output logic [3:0]   units_o
);
  logic [W+7:0] sh;

  // shift-and-add-3, values up to 99
  always_comb begin
    sh = {8'b0, bin_i};
    for (int i = 0; i < W; i++) begin
      if (sh[W+3:W]   >= 4'd5) sh[W+3:W]   = sh[W+3:W]   + 4'd3;
      if (sh[W+7:W+4] >= 4'd5) sh[W+7:W+4] = sh[W+7:W+4] + 4'd3;
      sh = sh << 1;
    end
  end

  assign tens_o  = sh[W+7:W+4];
  assign units_o = sh[W+3:W];
endmodule

// File: rtl/sheet_grader.sv
`timescale 1ns/1ps
module sheet_grader import grader_pkg::*; #(
  parameter int unsigned NUM_Q  = 10,
  parameter int unsigned FILT_N = 4,
  parameter int unsigned IDX_W  = $clog2(NUM_Q),
  parameter int unsigned CNT_W  = $clog2(NUM_Q + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic [IDX_W-1:0] key_idx_i,
  input  logic [3:0]       key_data_i,
  input  logic [CNT_W-1:0] q_limit_i,
  input  logic [3:0]       opt_i,
  input  logic             track_i,
  output logic [CNT_W-1:0] q_idx_o,
  output logic [CNT_W-1:0] correct_o,
  output logic [CNT_W-1:0] wrong_o,
  output logic [CNT_W-1:0] score_o,
  output logic [3:0]       corr_tens_o,
  output logic [3:0]       corr_units_o,
  output logic [3:0]       score_tens_o,
  output logic [3:0]       score_units_o,
  output logic             done_o
);
  logic adv;
  opt_t key_sel;
  logic [CNT_W-1:0] eff_limit;

  assign eff_limit = (q_limit_i == '0 || q_limit_i > CNT_W'(NUM_Q)) ? CNT_W'(NUM_Q) : q_limit_i;

  track_filter #(.FILT_N(FILT_N)) u_trk (
    .clk_i, .rst_ni, .track_i, .adv_o(adv)
  );

  key_store #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_key (
    .clk_i, .rst_ni,
    .we_i(key_we_i), .widx_i(key_idx_i), .wdata_i(key_data_i),
    .ridx_i(q_idx_o), .rdata_o(key_sel)
  );

  grade_tally #(.CNT_W(CNT_W)) u_tly (
    .clk_i, .rst_ni,
    .adv_i(adv), .opt_i(opt_i), .key_i(key_sel), .limit_i(eff_limit),
    .idx_o(q_idx_o), .correct_o(correct_o), .wrong_o(wrong_o),
    .score_o(score_o), .done_o(done_o)
  );

  bcd_split #(.W(CNT_W)) u_bcd_c (.bin_i(correct_o), .tens_o(corr_tens_o), .units_o(corr_units_o));
  bcd_split #(.W(CNT_W)) u_bcd_s (.bin_i(score_o), .tens_o(score_tens_o), .units_o(score_units_o));
endmodule

// File: rtl/sheet_grader_chk.sv
`timescale 1ns/1ps
module sheet_grader_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] q_idx_o,
  input logic [CNT_W-1:0] correct_o,
  input logic [CNT_W-1:0] wrong_o,
  input logic [CNT_W-1:0] score_o,
  input logic [3:0]       corr_units_o,
  input logic [3:0]       score_units_o,
  input logic             done_o
);
  a_r10_tally_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, correct_o} + {1'b0, wrong_o}) == {1'b0, q_idx_o});

  a_r4_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_idx_o != $past(q_idx_o)) |-> (q_idx_o == $past(q_idx_o) + 1'b1));

  a_r8_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(q_idx_o) && $stable(correct_o) && $stable(wrong_o));

  a_r6_score_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    score_o <= correct_o);

  a_r7_units_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_units_o < 4'd10 && score_units_o < 4'd10);
endmodule

bind sheet_grader sheet_grader_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .q_idx_o(q_idx_o), .correct_o(correct_o),
  .wrong_o(wrong_o), .score_o(score_o), .corr_units_o(corr_units_o),
  .score_units_o(score_units_o), .done_o(done_o)
);

// File: tb/sim_sheet_grader.sv
`timescale 1ns/1ps
module sim_sheet_grader;
  localparam int NQ = 10;
  localparam int FN = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic key_we = 1'b0;
  logic [3:0] key_idx = '0;
  logic [3:0] key_data = '0;
  logic [3:0] q_limit = '0;
  logic [3:0] opt = '0;
  logic track = 1'b0;
  logic [3:0] q_idx, cor, wrg, score, ct, cu, st, su;
  logic done;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [3:0] key_m [NQ];
  int e_idx, e_cor, e_wrg;

  always #5 clk = ~clk;

  sheet_grader #(.NUM_Q(NQ), .FILT_N(FN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .key_we_i(key_we), .key_idx_i(key_idx),
    .key_data_i(key_data), .q_limit_i(q_limit), .opt_i(opt), .track_i(track),
    .q_idx_o(q_idx), .correct_o(cor), .wrong_o(wrg), .score_o(score),
    .corr_tens_o(ct), .corr_units_o(cu), .score_tens_o(st), .score_units_o(su),
    .done_o(done)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; track = 1'b0; opt = '0; key_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NQ; i++) key_m[i] = '0;
    e_idx = 0; e_cor = 0; e_wrg = 0;
  endtask

  task automatic wr_key(int idx, logic [3:0] v);
    @(negedge clk);
    key_we = 1'b1; key_idx = 4'(idx); key_data = v;
    @(negedge clk);
    key_we = 1'b0;
    key_m[idx] = v;
  endtask

  task automatic check_all(string tag);
    int es;
    es = (e_cor >= e_wrg) ? e_cor - e_wrg : 0;
    chk({tag, " R4 idx"}, int'(q_idx), e_idx);
    chk({tag, " R5 correct"}, int'(cor), e_cor);
    chk({tag, " R5 wrong"}, int'(wrg), e_wrg);
    chk({tag, " R6 score"}, int'(score), es);
    chk({tag, " R7 bcd"}, int'({ct, cu, st, su}),
        int'({4'(e_cor / 10), 4'(e_cor % 10), 4'(es / 10), 4'(es % 10)}));
  endtask

  // one sheet row: shaded for 8 cycles (optional short glitch), then a gap of 8
  task automatic scan_q(logic [3:0] o, int lim, bit glitch);
    @(negedge clk);
    opt = o; track = 1'b1;
    repeat (8) @(negedge clk);
    if (glitch) begin
      track = 1'b0;
      repeat (FN - 1) @(negedge clk);
      track = 1'b1;
      repeat (8) @(negedge clk);
      chk("R3 glitch ignored", int'(q_idx), e_idx);
    end
    track = 1'b0;
    repeat (8) @(negedge clk);
    if (e_idx < lim) begin
      if (o == key_m[e_idx]) e_cor++; else e_wrg++;
      e_idx++;
    end
  endtask

  function automatic logic [3:0] wrong_for(logic [3:0] k, int i);
    case (i % 3)
      0: return 4'b0000;
      1: return k | ((k == 4'b0001) ? 4'b0010 : 4'b0001);
      default: return (k == 4'b1000) ? 4'b0001 : (k << 1);
    endcase
  endfunction

  initial begin
    do_reset();
    chk("R1 reset idx", int'(q_idx), 0);
    chk("R1 reset tallies", int'({cor, wrg, score}), 0);
    chk("R1 reset bcd", int'({ct, cu, st, su}), 0);
    chk("R1 reset done", int'(done), 0);

    // R1: key cleared by reset -> blank grades correct
    wr_key(0, 4'b0100);
    do_reset();
    scan_q(4'b0000, NQ, 1'b0);
    check_all("R1 key cleared");

    // R2/R5/R6/R7: sweep number of correct answers 0..NQ
    for (int c = 0; c <= NQ; c++) begin
      do_reset();
      q_limit = 4'd0;
      for (int i = 0; i < NQ; i++) wr_key(i, 4'(1 << ((i + c) % 4)));
      for (int i = 0; i < NQ; i++) begin
        scan_q((i < c) ? key_m[i] : wrong_for(key_m[i], i + c), NQ, (i == 3));
        check_all("R2 sweep");
      end
      chk("R8 done after full sheet", int'(done), 1);
    end

    // R8: programmable limit, extra rows ignored
    for (int l = 1; l <= NQ; l++) begin
      do_reset();
      q_limit = 4'(l);
      for (int i = 0; i < NQ; i++) wr_key(i, 4'(1 << (i % 4)));
      for (int i = 0; i < l + 2 && i < NQ; i++) begin
        scan_q((i % 2 == 0) ? key_m[i] : 4'b1111, l, 1'b0);
        check_all("R8 limit");
        chk("R8 done flag", int'(done), (e_idx >= l) ? 1 : 0);
      end
    end
    q_limit = 4'd0;

    // R9: key write to current question in the advance-pulse cycle
    do_reset();
    wr_key(0, 4'b0010);
    @(negedge clk);
    opt = 4'b0010; track = 1'b1;
    repeat (8) @(negedge clk);
    track = 1'b0;
    repeat (FN + 2) @(posedge clk);
    @(negedge clk);
    key_we = 1'b1; key_idx = 4'd0; key_data = 4'b1000;
    @(negedge clk);
    key_we = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 old key used", int'(cor), 1);
    chk("R9 wrong untouched", int'(wrg), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule